// File: doc/BRIEF.md
# Trigger-Rate Window Watchdog

This block supervises a periodic trigger that a microcontroller toggles while its software runs correctly. Each interval between two rising edges of the trigger is measured in cycles of a reference clock, whose rate is one hundred times the nominal trigger rate. Each interval is then sorted into one of four classes: too fast, in window, too slow, or dropped out. The window limits move by one cycle depending on whether the watchdog currently trusts the trigger, which gives the comparison hysteresis.

A single odd interval does not change the verdict. Three consecutive intervals outside the window are needed to withdraw trust, and three consecutive intervals inside it are needed to restore it. A trigger that stops altogether is treated as a fault at once, without waiting for further edges. The enable and relay-drive outputs are on only while the watchdog trusts the trigger and no supply fault is reported by the neighbouring reset circuit.

Top module: `trig_window_watchdog`

## Requirements
- R1: The trigger input passes through two synchronizing flip-flops, and only its rising edges mark interval boundaries. The interval is the exact number of reference cycles between two rising edges. A result (enable, relay, status) changes at the third clock edge counted from the first edge that samples the trigger high.
- R2: While trusted, an interval of 80 to 169 cycles inclusive is in window. Fewer than 80 cycles is too fast, and more than 169 is too slow.
- R3: While faulted, the window is 79 to 170 cycles inclusive. Fewer than 79 cycles is too fast, and more than 170 is too slow.
- R4: While trusted, three consecutive out-of-window intervals make the watchdog faulted. Any in-window interval restarts that run.
- R5: While faulted, three consecutive in-window intervals make the watchdog trusted. Any out-of-window interval restarts that run.
- R6: If 250 reference cycles pass after a detected rising edge with no further rising edge, the watchdog becomes faulted at once and reports dropout. After the trigger's last rising edge is first sampled, enable stays high for at least 251 clock edges and is low after 252. Any interval of 250 cycles or more is classed as dropout and faults at once, while 249 cycles is only too slow.
- R7: While supply_fault_i is high, enable and relay are low from the next clock edge on. The supply fault leaves the watchdog state untouched, so the outputs return one edge after it clears if the watchdog is trusted.
- R8: Reset puts the watchdog in the faulted state, with enable and relay low and status 3. The first rising edge after reset is classed as dropout.
- R9: status_o gives the class of the latest interval: 0 too fast, 1 in window, 2 too slow, 3 dropout. It changes only after a detected rising edge or a dropout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that all intervals are measured in |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Asynchronous trigger from the supervised controller |
| supply_fault_i | input | 1 | Supply-fault reset from the voltage monitor; forces the outputs off |
| enable_o | output | 1 | High while the trigger is trusted and the supply is good |
| relay_o | output | 1 | Relay drive, same condition as enable_o |
| status_o | output | 2 | Class of the latest interval (0 fast, 1 good, 2 slow, 3 dropout) |

## Verification
Corrupting the interval counter or the hysteresis selection shows up at status_o after the next rising edge. A period of exactly 79, 80, 169, 170 or 249 cycles is then reported in the wrong class. A wrong run counter shows on enable_o, which changes after two or four qualifying intervals instead of three, so a fault or a recovery is visible within about 500 reference cycles. A missed dropout leaves enable_o high past the 252nd clock edge after the last trigger. A supply fault that disturbs the state shows as enable_o staying low after the supply clears.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

    typedef enum logic [1:0] {
        RATE_FAST = 2'd0,
        RATE_GOOD = 2'd1,
        RATE_SLOW = 2'd2,
        RATE_DROP = 2'd3
    } rate_e;

    typedef enum logic {
        WD_FAULT = 1'b0,
        WD_OK    = 1'b1
    } wd_state_e;

    typedef struct packed {
        wd_state_e st;
        rate_e     stat;
    } wd_ctx_t;

    // Sort one measured interval against a window and the dropout limit.
    function automatic rate_e classify(input int unsigned period,
                                       input int unsigned lo,
                                       input int unsigned hi,
                                       input int unsigned drop);
        if (period >= drop)    return RATE_DROP;
        else if (period < lo)  return RATE_FAST;
        else if (period > hi)  return RATE_SLOW;
        else                   return RATE_GOOD;
    endfunction

endpackage

// File: rtl/wwd_trig_sync.sv
module wwd_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic rise_o
);
    logic ff [STAGES];
    logic prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) ff[g] <= 1'b0;
                    else     ff[g] <= trig_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) ff[g] <= 1'b0;
                    else     ff[g] <= ff[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= ff[STAGES-1];
    end

    assign rise_o = ff[STAGES-1] & ~prev_q;

endmodule

// File: rtl/wwd_period_meter.sv
module wwd_period_meter #(
    parameter  int DROP_LIM = 250,
    localparam int CW       = $clog2(DROP_LIM + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise_i,
    output logic [CW-1:0] period_o,
    output logic          drop_o
);
    localparam logic [CW-1:0] SAT  = CW'(DROP_LIM);
    localparam logic [CW-1:0] LAST = CW'(DROP_LIM - 1);

    logic [CW-1:0] cnt_q;

    // Starts saturated so the first edge after reset has no valid reference.
    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= SAT;
        else if (rise_i)        cnt_q <= CW'(1);
        else if (cnt_q != SAT)  cnt_q <= cnt_q + 1'b1;
    end

    assign period_o = cnt_q;
    // One pulse as the counter is about to saturate without a new edge.
    assign drop_o   = (cnt_q == LAST) && !rise_i;

endmodule

// File: rtl/wwd_qualifier.sv
module wwd_qualifier
    import wwd_pkg::*;
#(
    parameter  int LO_OK    = 80,
    parameter  int HI_OK    = 169,
    parameter  int LO_FLT   = 79,
    parameter  int HI_FLT   = 170,
    parameter  int DROP_LIM = 250,
    parameter  int QUAL_RUN = 3,
    parameter  int CW       = 8,
    localparam int QW       = $clog2(QUAL_RUN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise_i,
    input  logic          drop_i,
    input  logic [CW-1:0] period_i,
    output wd_state_e     st_next_o,
    output rate_e         status_o
);
    localparam logic [QW-1:0] RUN_LAST = QW'(QUAL_RUN - 1);

    wd_ctx_t       ctx_q, ctx_d;
    logic [QW-1:0] run_q, run_d;
    rate_e         cls;

    always_comb begin
        if (ctx_q.st == WD_OK)
            cls = classify(32'(period_i), LO_OK, HI_OK, DROP_LIM);
        else
            cls = classify(32'(period_i), LO_FLT, HI_FLT, DROP_LIM);

        ctx_d = ctx_q;
        run_d = run_q;

        if (drop_i) begin
            ctx_d.st   = WD_FAULT;
            ctx_d.stat = RATE_DROP;
            run_d      = '0;
        end else if (rise_i) begin
            ctx_d.stat = cls;
            if (cls == RATE_DROP) begin
                ctx_d.st = WD_FAULT;
                run_d    = '0;
            end else if (ctx_q.st == WD_OK) begin
                if (cls == RATE_GOOD) begin
                    run_d = '0;
                end else if (run_q == RUN_LAST) begin
                    ctx_d.st = WD_FAULT;
                    run_d    = '0;
                end else begin
                    run_d = run_q + 1'b1;
                end
            end else begin
                if (cls != RATE_GOOD) begin
                    run_d = '0;
                end else if (run_q == RUN_LAST) begin
                    ctx_d.st = WD_OK;
                    run_d    = '0;
                end else begin
                    run_d = run_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '{st: WD_FAULT, stat: RATE_DROP};
            run_q <= '0;
        end else begin
            ctx_q <= ctx_d;
            run_q <= run_d;
        end
    end

    assign st_next_o = ctx_d.st;
    assign status_o  = ctx_q.stat;

endmodule

// File: rtl/trig_window_watchdog.sv
module trig_window_watchdog
    import wwd_pkg::*;
#(
    parameter int LO_OK       = 80,
    parameter int HI_OK       = 169,
    parameter int LO_FLT      = 79,
    parameter int HI_FLT      = 170,
    parameter int DROP_LIM    = 250,
    parameter int QUAL_RUN    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig_i,
    input  logic       supply_fault_i,
    output logic       enable_o,
    output logic       relay_o,
    output logic [1:0] status_o
);
    localparam int CW = $clog2(DROP_LIM + 1);

    logic          rise_w;
    logic          drop_w;
    logic [CW-1:0] period_w;
    wd_state_e     st_next_w;
    rate_e         status_w;
    logic          en_q;

    wwd_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .trig_i (trig_i),
        .rise_o (rise_w)
    );

    wwd_period_meter #(.DROP_LIM(DROP_LIM)) u_meter (
        .clk      (clk),
        .rst      (rst),
        .rise_i   (rise_w),
        .period_o (period_w),
        .drop_o   (drop_w)
    );

    wwd_qualifier #(
        .LO_OK    (LO_OK),
        .HI_OK    (HI_OK),
        .LO_FLT   (LO_FLT),
        .HI_FLT   (HI_FLT),
        .DROP_LIM (DROP_LIM),
        .QUAL_RUN (QUAL_RUN),
        .CW       (CW)
    ) u_qual (
        .clk       (clk),
        .rst       (rst),
        .rise_i    (rise_w),
        .drop_i    (drop_w),
        .period_i  (period_w),
        .st_next_o (st_next_w),
        .status_o  (status_w)
    );

    // Output register follows the next watchdog state, gated by the supply.
    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= (st_next_w == WD_OK) && !supply_fault_i;
    end

    assign enable_o = en_q;
    assign relay_o  = en_q;
    assign status_o = status_w;

endmodule

// File: rtl/wwd_checker.sv
module wwd_checker (
    input logic       clk,
    input logic       rst,
    input logic       supply_fault_i,
    input logic       enable_o,
    input logic       relay_o,
    input logic [1:0] status_o,
    input logic       edge_pulse,
    input logic       drop_hit
);
    // R7
    supply_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $past(supply_fault_i) |-> (!enable_o && !relay_o));

    // R8
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!enable_o && status_o == 2'd3));

    // R6
    dropout_kill_chk: assert property (@(posedge clk) disable iff (rst)
        drop_hit |=> (!enable_o && status_o == 2'd3));

    // R9
    status_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(status_o) |-> ($past(edge_pulse) || $past(drop_hit)));

    // R5
    enable_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(enable_o) |-> ($past(edge_pulse) || $past(supply_fault_i, 2)));

endmodule

bind trig_window_watchdog wwd_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .supply_fault_i (supply_fault_i),
    .enable_o       (enable_o),
    .relay_o        (relay_o),
    .status_o       (status_o),
    .edge_pulse     (rise_w),
    .drop_hit       (drop_w)
);

// File: tb/trig_window_watchdog_bench.sv
`timescale 1ns/1ps
module trig_window_watchdog_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trig = 1'b0;
    logic       sfault = 1'b0;
    logic       enable_o;
    logic       relay_o;
    logic [1:0] status_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    trig_window_watchdog u_trig_window_watchdog (
        .clk            (clk),
        .rst            (rst),
        .trig_i         (trig),
        .supply_fault_i (sfault),
        .enable_o       (enable_o),
        .relay_o        (relay_o),
        .status_o       (status_o)
    );

    // Interval, expected enable, expected status, requirement number.
    localparam int NV = 21;
    localparam int VP [NV] = '{100, 100, 100, 100, 169, 80, 170, 79, 100, 249, 100,
                               60, 200, 40, 170, 79, 171, 78, 100, 100, 100};
    localparam int VE [NV] = '{0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 1,
                               1, 1, 0, 0, 0, 0, 0, 0, 0, 1};
    localparam int VS [NV] = '{3, 1, 1, 1, 1, 1, 2, 0, 1, 2, 1,
                               0, 2, 0, 1, 1, 2, 0, 1, 1, 1};
    // R8 first edge, R5 recovery, R2 trusted window, R4 run, R6 249 boundary,
    // R4 fault entry, R3 faulted window, R5 recovery again
    localparam int VR [NV] = '{8, 5, 5, 5, 2, 2, 2, 2, 4, 6, 4,
                               4, 4, 4, 3, 3, 3, 3, 5, 5, 5};

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_outs(input string tag, input int en, input int st);
        chk({tag, " enable"}, int'(enable_o), en);
        chk({tag, " relay"},  int'(relay_o),  en);
        chk({tag, " status"}, int'(status_o), st);
    endtask

    // Entered at (previous rise + hi); leaves at (this rise + hi).
    task automatic do_period(input int p, input int hi, input int en, input int st,
                             input string tag);
        repeat (p - hi) @(negedge clk);
        trig = 1'b1;
        repeat (5) @(negedge clk);
        check_outs(tag, en, st);
        repeat (hi - 5) @(negedge clk);
        trig = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_outs("R8 after reset", 0, 3);

        for (int i = 0; i < NV; i++) begin
            do_period(VP[i], 10, VE[i], VS[i], $sformatf("R%0d vec %0d", VR[i], i));
        end

        // R6: trigger stops; now 10 edges after last rise was sampled
        repeat (240) @(negedge clk);
        chk("R6 enable before dropout", int'(enable_o), 1);
        repeat (3) @(negedge clk);
        chk("R6 enable after dropout", int'(enable_o), 0);
        chk("R6 status after dropout", int'(status_o), 3);
        do_period(20, 10, 0, 3, "R6 saturated interval");
        do_period(100, 10, 0, 1, "R5 rec1");
        do_period(100, 10, 0, 1, "R5 rec2");
        do_period(100, 10, 1, 1, "R5 rec3");

        // R7: supply fault gates outputs, state kept
        sfault = 1'b1;
        repeat (2) @(negedge clk);
        check_outs("R7 supply fault", 0, 1);
        sfault = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 supply released enable", int'(enable_o), 1);
        do_period(96, 10, 1, 1, "R7 state kept");

        // R8: reset during trusted operation
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_outs("R8 mid-run reset", 0, 3);

        // R1: long high time, only rising edges define the interval
        do_period(100, 60, 0, 3, "R1 first edge");
        do_period(100, 60, 0, 1, "R1 p1");
        do_period(100, 60, 0, 1, "R1 p2");
        do_period(100, 60, 1, 1, "R1 p3");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule